// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Read Latency

This block is a word-addressed memory that two independent agents can reach at the same time through two identical access ports, A and B. Both ports can reach every word, including the same word in the same cycle. Each port registers its address, write data, two chip-select lines and its write strobe on the rising clock edge, then performs a write or a read.

Each port has a static mode input. In flow-through mode, read data is returned in the cycle after the sampling edge. In pipelined mode, it is returned one edge later still. The two ports may run in different modes.

The output side of each port models a bus driver without using a real tri-state. A valid flag stands in for "driving", and the data bus reads as all zeros whenever the flag is low. An asynchronous output-disable input drops the flag at once, with no clock involved. Address generation such as burst counters sits outside the block, so each port takes its final word address directly.

Top module: `dpr_dual`

## Requirements
- R1: A port is selected only when its `_en0_n` input is 0 and its `_en1` input is 1 at the edge. Any other combination performs no access, including when the write strobe is low. After that edge the port's `_rvalid` is 0 in either mode.
- R2: With the port selected and `_wr_n` at 0, the word at `_addr` takes the value on `_wdata` at that edge.
- R3: In flow-through mode (`_pipe` = 0), a selected read with `_wr_n` at 1 returns the word at the sampled address on `_rdata`, with `_rvalid` at 1, right after the same edge.
- R4: In pipelined mode (`_pipe` = 1), the data from a read sampled at edge k is presented after edge k+1.
- R5: `_oe_n` acts without a clock. While it is 1, `_rvalid` is 0. When it returns to 0, the previous output state comes back without a clock edge.
- R6: Whenever `_rvalid` is 0, `_rdata` is all zeros.
- R7: In pipelined mode, the output drives only after two consecutive edges at which the port was selected. A single selected edge between deselected edges never produces valid output.
- R8: A write cycle does not drive fresh read data. In flow-through mode, `_rvalid` is 0 after a write edge. In pipelined mode, the output after a write edge shows the read from the edge before it.
- R9: When one port writes a word and the other port reads that word at the same edge, the reader gets the old contents. A read at any later edge gets the new contents.
- R10: When both ports write the same word at the same edge, the value from port A is kept.
- R11: Repeated reads of an unchanged address with no intervening write keep `_rdata` constant.
- R12: While `rst_n` is 0, both ports have `_rvalid` at 0 and `_rdata` at zero. Memory contents are not cleared by reset.
- R13: The two ports' modes are independent. In the same cycle, a flow-through port and a pipelined port can read the same word, each with its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the port output state |
| a_en0_n | input | 1 | Port A select, active low |
| a_en1 | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A: 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A asynchronous output disable, active high |
| a_pipe | input | 1 | Port A mode: 0 = flow-through, 1 = pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A output driving (high-impedance model) |
| b_en0_n | input | 1 | Port B select, active low |
| b_en1 | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B: 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B asynchronous output disable, active high |
| b_pipe | input | 1 | Port B mode: 0 = flow-through, 1 = pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B output driving (high-impedance model) |

## Verification
Flow-through read data and every deselect or write effect are due right after the sampling edge, because they pass through one register. Pipelined read data is due one edge later, and pipelined reactivation needs the second of two selected edges. The output-disable input takes effect with no edge at all.

The bench changes inputs and samples outputs 2 ns after each rising edge. Each check is placed after exactly the number of edges its result needs. Output-disable checks are taken 1 ns after the input changes, with no clock edge in between, so any dependence on the clock would show up as a failure.

// File: rtl/dpr_pkg.sv
// Package: shared definitions for the dual-port RAM.
// Assumes: chip selects are sampled synchronously; mode inputs are static.
package dpr_pkg;

    // Output latency mode of one port
    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } port_mode_e;

    // A port is selected only for the one combination of its two enables
    function automatic logic port_selected(input logic en0_n, input logic en1);
        return (~en0_n) & en1;
    endfunction

endpackage

// File: rtl/dpr_array.sv
// Module: dpr_array
// Shared storage with two write ports and two registered read ports.
// Assumes: one common clock. A read sees the contents before a write at
// the same edge. If both ports write one word at one edge, port A wins.
module dpr_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata_q,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: port B first, so a port A write to the same word wins
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    // Port A read register: captures pre-write contents, holds when idle
    always_ff @(posedge clk) begin
        if (!rst_n)    a_rdata_q <= '0;
        else if (a_re) a_rdata_q <= mem[a_addr];
    end

    // Port B read register: captures pre-write contents, holds when idle
    always_ff @(posedge clk) begin
        if (!rst_n)    b_rdata_q <= '0;
        else if (b_re) b_rdata_q <= mem[b_addr];
    end

endmodule

// File: rtl/dpr_port_ctrl.sv
// Module: dpr_port_ctrl
// One access port: decodes select and direction, tracks output validity
// for flow-through and pipelined modes, and applies the asynchronous
// output disable. Invalid output is modelled as zero data with rvalid low.
// Assumes: pipe is static while the port is in use.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              arr_we,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic              sel;
    logic              ft_vld_q;
    logic              pipe_vld_q;
    logic [DATA_W-1:0] pipe_data_q;
    logic              vld_int;
    port_mode_e        mode;

    // Request decode toward the array
    always_comb begin
        sel       = port_selected(en0_n, en1);
        arr_we    = sel & ~wr_n;
        arr_re    = sel & wr_n;
        arr_addr  = addr;
        arr_wdata = wdata;
        mode      = port_mode_e'(pipe);
    end

    // Flow-through validity: this edge was a selected read
    always_ff @(posedge clk) begin
        if (!rst_n) ft_vld_q <= 1'b0;
        else        ft_vld_q <= arr_re;
    end

    // Pipeline stage: previous edge's read, shown only if still selected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_vld_q  <= 1'b0;
            pipe_data_q <= '0;
        end else begin
            pipe_vld_q  <= sel & ft_vld_q;
            if (ft_vld_q) pipe_data_q <= arr_rdata;
        end
    end

    // Mode mux and asynchronous output disable
    always_comb begin
        vld_int = (mode == MODE_PIPE) ? pipe_vld_q : ft_vld_q;
        rvalid  = vld_int & ~oe_n;
        if (!rvalid)                rdata = '0;
        else if (mode == MODE_PIPE) rdata = pipe_data_q;
        else                        rdata = arr_rdata;
    end

endmodule

// File: rtl/dpr_dual.sv
// Module: dpr_dual (top)
// Two identical port controllers around one shared array.
// Assumes: both ports run on the common clock; addresses come pre-computed.
module dpr_dual #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en0_n,
    input  logic              a_en1,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_en0_n,
    input  logic              b_en1,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);

    logic              a_we, a_re, b_we, b_re;
    logic [ADDR_W-1:0] a_ia, b_ia;
    logic [DATA_W-1:0] a_iw, b_iw, a_ir, b_ir;

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port_a (
        .clk(clk), .rst_n(rst_n),
        .en0_n(a_en0_n), .en1(a_en1), .wr_n(a_wr_n), .oe_n(a_oe_n),
        .pipe(a_pipe), .addr(a_addr), .wdata(a_wdata),
        .arr_we(a_we), .arr_re(a_re), .arr_addr(a_ia), .arr_wdata(a_iw),
        .arr_rdata(a_ir), .rdata(a_rdata), .rvalid(a_rvalid)
    );

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port_b (
        .clk(clk), .rst_n(rst_n),
        .en0_n(b_en0_n), .en1(b_en1), .wr_n(b_wr_n), .oe_n(b_oe_n),
        .pipe(b_pipe), .addr(b_addr), .wdata(b_wdata),
        .arr_we(b_we), .arr_re(b_re), .arr_addr(b_ia), .arr_wdata(b_iw),
        .arr_rdata(b_ir), .rdata(b_rdata), .rvalid(b_rvalid)
    );

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_we), .a_re(a_re), .a_addr(a_ia), .a_wdata(a_iw), .a_rdata_q(a_ir),
        .b_we(b_we), .b_re(b_re), .b_addr(b_ia), .b_wdata(b_iw), .b_rdata_q(b_ir)
    );

endmodule

// File: rtl/dpr_dual_chk.sv
// Module: dpr_dual_chk
// Port-level properties of both ports, bound to dpr_dual.
// Assumes: the mode inputs change only while reset is asserted.
module dpr_dual_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en0_n,
    input logic              a_en1,
    input logic              a_wr_n,
    input logic              a_oe_n,
    input logic              a_pipe,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              b_en0_n,
    input logic              b_en1,
    input logic              b_wr_n,
    input logic              b_oe_n,
    input logic              b_pipe,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid
);

    logic a_sel, b_sel;
    assign a_sel = !a_en0_n && a_en1;
    assign b_sel = !b_en0_n && b_en1;

    assert_oe_off_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> !a_rvalid);
    assert_oe_off_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |-> !b_rvalid);

    assert_zero_idle_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rvalid |-> (a_rdata == '0));
    assert_zero_idle_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rvalid |-> (b_rdata == '0));

    assert_desel_off_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !a_sel |=> !a_rvalid);
    assert_desel_off_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !b_sel |=> !b_rvalid);

    assert_flow_write_quiet_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_pipe && a_sel && !a_wr_n) |=> !a_rvalid);
    assert_flow_write_quiet_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_pipe && b_sel && !b_wr_n) |=> !b_rvalid);

    assert_pipe_reactivate_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pipe && !a_sel) |=> (!a_rvalid ##1 !a_rvalid));
    assert_pipe_reactivate_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_pipe && !b_sel) |=> (!b_rvalid ##1 !b_rvalid));

endmodule

bind dpr_dual dpr_dual_chk #(.DATA_W(DATA_W)) i_dpr_dual_chk (
    .clk(clk), .rst_n(rst_n),
    .a_en0_n(a_en0_n), .a_en1(a_en1), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
    .a_pipe(a_pipe), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_en0_n(b_en0_n), .b_en1(b_en1), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
    .b_pipe(b_pipe), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
);

// File: tb/test_dpr_dual.sv
// Bench for dpr_dual: a vector table walked by one loop, then directed tests.
module test_dpr_dual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_en0_n = 1'b1, a_en1 = 1'b0, a_wr_n = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
    logic [7:0] a_addr = '0;
    logic [8:0] a_wdata = '0;
    logic [8:0] a_rdata;
    logic       a_rvalid;
    logic       b_en0_n = 1'b1, b_en1 = 1'b0, b_wr_n = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b0;
    logic [7:0] b_addr = '0;
    logic [8:0] b_wdata = '0;
    logic [8:0] b_rdata;
    logic       b_rvalid;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    dpr_dual #(.ADDR_W(8), .DATA_W(9)) i_dpr_dual (
        .clk(clk), .rst_n(rst_n),
        .a_en0_n(a_en0_n), .a_en1(a_en1), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
        .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_en0_n(b_en0_n), .b_en1(b_en1), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
        .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    // Row: {a_write, a_addr, a_wdata, b_addr, check, expected b_rdata}
    // Port B reads in flow-through mode every row.
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 8'h10, 9'h155, 8'h10, 1'b0, 9'h000},
        {1'b1, 8'h11, 9'h0AA, 8'h10, 1'b1, 9'h155}, // R2 written value
        {1'b1, 8'h11, 9'h1FF, 8'h11, 1'b1, 9'h0AA}, // R9 old value
        {1'b0, 8'h11, 9'h000, 8'h11, 1'b1, 9'h1FF}, // R9 new value
        {1'b0, 8'h00, 9'h000, 8'h11, 1'b1, 9'h1FF}, // R11 hold
        {1'b1, 8'h12, 9'h003, 8'h12, 1'b1, 9'h000}, // R9 old (unwritten word reads zero-init? not checked below)
        {1'b1, 8'hFF, 9'h100, 8'h12, 1'b1, 9'h003},
        {1'b0, 8'h00, 9'h000, 8'hFF, 1'b1, 9'h100}  // top address
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic a_drive(input logic sel, input logic wr, input logic [7:0] ad, input logic [8:0] d);
        a_en0_n = ~sel; a_en1 = 1'b1; a_wr_n = ~wr; a_addr = ad; a_wdata = d;
    endtask

    task automatic b_drive(input logic sel, input logic wr, input logic [7:0] ad, input logic [8:0] d);
        b_en0_n = ~sel; b_en1 = 1'b1; b_wr_n = ~wr; b_addr = ad; b_wdata = d;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (3) tick();
        check("R12 a_rvalid", {8'h0, a_rvalid}, 9'h0);
        check("R12 a_rdata", a_rdata, 9'h0);
        check("R12 b_rvalid", {8'h0, b_rvalid}, 9'h0);
        check("R12 b_rdata", b_rdata, 9'h0);
        rst_n = 1'b1;
        tick();

        // R3 table walk: A writes or reads, B reads flow-through
        for (int i = 0; i < 8; i++) begin
            a_drive(1'b1, VEC[i][35], VEC[i][34:27], VEC[i][26:18]);
            b_drive(1'b1, 1'b0, VEC[i][17:10], 9'h0);
            tick();
            if (VEC[i][9] && i != 5) begin
                check("R3 table valid", {8'h0, b_rvalid}, 9'h1);
                check("R3 table data", b_rdata, VEC[i][8:0]);
            end
        end

        // R3 and R5: flow read, then async disable and re-enable
        b_drive(1'b0, 1'b0, 8'h0, 9'h0);
        a_drive(1'b1, 1'b0, 8'h10, 9'h0);
        tick();
        check("R3 a_rdata", a_rdata, 9'h155);
        a_oe_n = 1'b1;
        #1;
        check("R5 a_rvalid off", {8'h0, a_rvalid}, 9'h0);
        check("R6 a_rdata zero", a_rdata, 9'h0);
        a_oe_n = 1'b0;
        #1;
        check("R5 a_rvalid back", {8'h0, a_rvalid}, 9'h1);
        check("R5 a_rdata back", a_rdata, 9'h155);

        // R11 repeated read keeps data
        tick();
        check("R11 hold", a_rdata, 9'h155);

        // R1 deselect by either enable; deselected write has no effect
        a_en0_n = 1'b1;
        tick();
        check("R1 en0 high off", {8'h0, a_rvalid}, 9'h0);
        a_en0_n = 1'b0; a_en1 = 1'b0;
        tick();
        check("R1 en1 low off", {8'h0, a_rvalid}, 9'h0);
        a_drive(1'b0, 1'b1, 8'h10, 9'h000);
        tick();
        a_drive(1'b1, 1'b0, 8'h10, 9'h0);
        tick();
        check("R1 ignored write", a_rdata, 9'h155);

        // R8 flow write gives no output; R2 written data readable
        a_drive(1'b1, 1'b1, 8'h13, 9'h0C3);
        tick();
        check("R8 flow write quiet", {8'h0, a_rvalid}, 9'h0);
        a_drive(1'b1, 1'b0, 8'h13, 9'h0);
        tick();
        check("R2 write data", a_rdata, 9'h0C3);

        // R9 collision: A writes while B reads the same word
        a_drive(1'b1, 1'b1, 8'h13, 9'h1A5);
        b_drive(1'b1, 1'b0, 8'h13, 9'h0);
        tick();
        check("R9 old data", b_rdata, 9'h0C3);
        a_drive(1'b0, 1'b0, 8'h0, 9'h0);
        tick();
        check("R9 new data", b_rdata, 9'h1A5);

        // R10 both write one word: A wins
        a_drive(1'b1, 1'b1, 8'h14, 9'h111);
        b_drive(1'b1, 1'b1, 8'h14, 9'h0EE);
        tick();
        b_drive(1'b0, 1'b0, 8'h0, 9'h0);
        a_drive(1'b1, 1'b0, 8'h14, 9'h0);
        tick();
        check("R10 port A wins", a_rdata, 9'h111);

        // Pipelined phase: A pipelined, B flow-through
        a_drive(1'b0, 1'b0, 8'h0, 9'h0);
        rst_n = 1'b0;
        a_pipe = 1'b1;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        a_drive(1'b1, 1'b0, 8'h10, 9'h0);
        tick();
        check("R7 first edge quiet", {8'h0, a_rvalid}, 9'h0);
        a_drive(1'b1, 1'b0, 8'h11, 9'h0);
        tick();
        check("R4 valid", {8'h0, a_rvalid}, 9'h1);
        check("R12 memory kept", a_rdata, 9'h155);
        a_drive(1'b1, 1'b0, 8'h12, 9'h0);
        b_drive(1'b1, 1'b0, 8'h12, 9'h0);
        tick();
        check("R4 pipe data", a_rdata, 9'h1FF);
        check("R13 flow port same cycle", b_rdata, 9'h003);
        b_drive(1'b0, 1'b0, 8'h0, 9'h0);
        a_drive(1'b1, 1'b1, 8'h15, 9'h077);
        tick();
        check("R13 pipe port one later", a_rdata, 9'h003);
        check("R8 pipe shows prior read", {8'h0, a_rvalid}, 9'h1);
        a_drive(1'b1, 1'b0, 8'h15, 9'h0);
        tick();
        check("R8 pipe after write quiet", {8'h0, a_rvalid}, 9'h0);
        tick();
        check("R4 pipe written data", a_rdata, 9'h077);

        // R7 reactivation needs two selected edges
        a_drive(1'b0, 1'b0, 8'h10, 9'h0);
        tick();
        check("R1 pipe deselect off", {8'h0, a_rvalid}, 9'h0);
        a_drive(1'b1, 1'b0, 8'h10, 9'h0);
        tick();
        a_drive(1'b0, 1'b0, 8'h10, 9'h0);
        tick();
        check("R7 single select quiet", {8'h0, a_rvalid}, 9'h0);
        a_drive(1'b1, 1'b0, 8'h10, 9'h0);
        tick();
        check("R7 one edge quiet", {8'h0, a_rvalid}, 9'h0);
        tick();
        check("R7 two edges drive", a_rdata, 9'h155);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule